// File: doc/BRIEF.md
# NAND Flash Command Sequence Decoder

This block sits on the device side of a NAND flash bus and works out which array operation the host has asked for. It watches the write-enable line for a rising edge, in the core clock domain. An edge with command latch high is a command byte. An edge with only address latch high is an address cycle. An edge with neither is a data cycle. Single-byte commands start an operation at once. Two-byte commands are held pending until their confirm byte arrives, and they need at least one address cycle before the confirm.

When a sequence completes, the block raises a one-cycle start strobe together with a 4-bit operation code. A busy input, with a qualifier saying the busy period comes from a cache read, filters out commands that the array cannot take while it works. Any byte that does not fit a pending sequence drops that sequence without starting anything. The reset command always wins.

Top module: `nand_cmd_decoder`

## Requirements
- R1: A command byte is taken only on a rising edge of we_i while cle_i is high. Rising edges with cle_i low, and clock cycles with no rising edge, never start an operation.
- R2: The sequence 00h, one or more address cycles, 30h starts code 0 (page read). The sequence 00h, address cycles, 35h starts code 6 (copy-back source read).
- R3: The sequence 05h, address cycles, E0h starts code 1 (random data output).
- R4: The sequence 80h, address cycles, any data cycles, 10h starts code 4 (page program). Ending the same sequence with 15h starts code 5 (cache program). A byte of 85h inside this sequence keeps it pending without a pulse.
- R5: The sequence 85h from idle, address cycles, 10h starts code 7 (copy-back program).
- R6: The sequence 60h, address cycles, D0h starts code 8 (block erase).
- R7: The single-cycle bytes start operations at once: 31h gives code 2 (cache read), 34h gives code 3 (exit cache read), 90h gives code 10 (signature read), and 70h gives code 11 (status read).
- R8: While busy_i is high, only FFh and 70h are accepted, plus 34h when cache_busy_i is also high. Any other command byte is ignored and leaves a pending sequence untouched.
- R9: While a sequence is pending, any accepted byte that is not one of its confirms aborts it silently. A confirm with no address cycle since the first byte also aborts it silently.
- R10: FFh is accepted in every state, busy or not. It clears any pending sequence and starts code 9 (reset).
- R11: op_valid_o is high for exactly one clock, in the cycle after the clock edge that saw the we_i rising edge, and op_code_o holds a defined code (0 to 11) while it is high.
- R12: After rst_ni, op_valid_o is low and no sequence is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write-enable level, already in the clock domain |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| io_i | input | 8 | I/O bus byte |
| busy_i | input | 1 | Array busy |
| cache_busy_i | input | 1 | Busy period comes from a cache read |
| op_valid_o | output | 1 | One-cycle operation start strobe |
| op_code_o | output | 4 | Operation code, valid with op_valid_o |

## Verification
Directed sequences drive every two-cycle command with its correct confirm, with a confirm that belongs to another command, and with the address phase left out. This separates true sequence tracking from plain opcode matching. Busy-period cases compare 34h with and without the cache qualifier, and they insert ignored confirms inside a pending erase to show the pending state survives. Random streams mix command, address and data cycles with random busy levels, so that interleavings nobody wrote by hand are scored against a bench reference model.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;
  localparam int IO_W = 8;
  localparam int OP_W = 4;

  localparam logic [IO_W-1:0] CMD_READ      = 8'h00;
  localparam logic [IO_W-1:0] CMD_READ_GO   = 8'h30;
  localparam logic [IO_W-1:0] CMD_CB_READ   = 8'h35;
  localparam logic [IO_W-1:0] CMD_RDOUT     = 8'h05;
  localparam logic [IO_W-1:0] CMD_RDOUT_GO  = 8'hE0;
  localparam logic [IO_W-1:0] CMD_PROG      = 8'h80;
  localparam logic [IO_W-1:0] CMD_DATA_IN   = 8'h85;
  localparam logic [IO_W-1:0] CMD_PROG_GO   = 8'h10;
  localparam logic [IO_W-1:0] CMD_CPROG_GO  = 8'h15;
  localparam logic [IO_W-1:0] CMD_ERASE     = 8'h60;
  localparam logic [IO_W-1:0] CMD_ERASE_GO  = 8'hD0;
  localparam logic [IO_W-1:0] CMD_CACHE_RD  = 8'h31;
  localparam logic [IO_W-1:0] CMD_CACHE_END = 8'h34;
  localparam logic [IO_W-1:0] CMD_RESET     = 8'hFF;
  localparam logic [IO_W-1:0] CMD_SIG       = 8'h90;
  localparam logic [IO_W-1:0] CMD_STATUS    = 8'h70;

  localparam logic [OP_W-1:0] OP_READ       = 4'd0;
  localparam logic [OP_W-1:0] OP_RDOUT      = 4'd1;
  localparam logic [OP_W-1:0] OP_CACHE_RD   = 4'd2;
  localparam logic [OP_W-1:0] OP_CACHE_END  = 4'd3;
  localparam logic [OP_W-1:0] OP_PROG       = 4'd4;
  localparam logic [OP_W-1:0] OP_CPROG      = 4'd5;
  localparam logic [OP_W-1:0] OP_CB_READ    = 4'd6;
  localparam logic [OP_W-1:0] OP_CB_PROG    = 4'd7;
  localparam logic [OP_W-1:0] OP_ERASE      = 4'd8;
  localparam logic [OP_W-1:0] OP_RESET      = 4'd9;
  localparam logic [OP_W-1:0] OP_SIG        = 4'd10;
  localparam logic [OP_W-1:0] OP_STATUS     = 4'd11;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_READ,
    SQ_RDOUT,
    SQ_PROG,
    SQ_CBPROG,
    SQ_ERASE
  } seq_e;
endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
  import nand_cmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            cle_i,
  input  logic            ale_i,
  input  logic [IO_W-1:0] io_i,
  output logic            cmd_stb_o,
  output logic            addr_stb_o,
  output logic [IO_W-1:0] byte_o
);
  logic we_q;
  logic we_rise;

  // idle-high line: reset high so no false edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_i;
  end

  assign we_rise    = we_i & ~we_q;
  assign cmd_stb_o  = we_rise & cle_i;
  assign addr_stb_o = we_rise & ale_i & ~cle_i;
  assign byte_o     = io_i;
endmodule

// File: rtl/nand_busy_filter.sv
module nand_busy_filter
  import nand_cmd_pkg::*;
(
  input  logic            cmd_stb_i,
  input  logic [IO_W-1:0] byte_i,
  input  logic            busy_i,
  input  logic            cache_busy_i,
  output logic            cmd_ok_o
);
  logic allowed_busy;

  always_comb begin
    allowed_busy = (byte_i == CMD_RESET) || (byte_i == CMD_STATUS) ||
                   ((byte_i == CMD_CACHE_END) && cache_busy_i);
    cmd_ok_o = cmd_stb_i && (!busy_i || allowed_busy);
  end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_cmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_ok_i,
  input  logic            addr_stb_i,
  input  logic [IO_W-1:0] byte_i,
  output logic            op_valid_o,
  output logic [OP_W-1:0] op_code_o
);
  seq_e            state_q, state_d;
  logic            addr_q, addr_d;
  logic            fire;
  logic [OP_W-1:0] code;
  logic            valid_q;
  logic [OP_W-1:0] code_q;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    fire    = 1'b0;
    code    = code_q;

    if (addr_stb_i && state_q != SQ_IDLE) addr_d = 1'b1;

    if (cmd_ok_i) begin
      if (byte_i == CMD_RESET) begin
        state_d = SQ_IDLE;
        addr_d  = 1'b0;
        fire    = 1'b1;
        code    = OP_RESET;
      end else if (state_q == SQ_IDLE) begin
        addr_d = 1'b0;
        case (byte_i)
          CMD_READ:      state_d = SQ_READ;
          CMD_RDOUT:     state_d = SQ_RDOUT;
          CMD_PROG:      state_d = SQ_PROG;
          CMD_DATA_IN:   state_d = SQ_CBPROG;
          CMD_ERASE:     state_d = SQ_ERASE;
          CMD_CACHE_RD:  begin fire = 1'b1; code = OP_CACHE_RD;  end
          CMD_CACHE_END: begin fire = 1'b1; code = OP_CACHE_END; end
          CMD_SIG:       begin fire = 1'b1; code = OP_SIG;       end
          CMD_STATUS:    begin fire = 1'b1; code = OP_STATUS;    end
          default:       ;
        endcase
      end else begin
        // pending: default is silent abort
        state_d = SQ_IDLE;
        addr_d  = 1'b0;
        case (state_q)
          SQ_READ: begin
            if (addr_q && byte_i == CMD_READ_GO) begin
              fire = 1'b1; code = OP_READ;
            end else if (addr_q && byte_i == CMD_CB_READ) begin
              fire = 1'b1; code = OP_CB_READ;
            end
          end
          SQ_RDOUT: begin
            if (addr_q && byte_i == CMD_RDOUT_GO) begin
              fire = 1'b1; code = OP_RDOUT;
            end
          end
          SQ_PROG: begin
            if (byte_i == CMD_DATA_IN) begin
              state_d = SQ_PROG;
              addr_d  = addr_q;
            end else if (addr_q && byte_i == CMD_PROG_GO) begin
              fire = 1'b1; code = OP_PROG;
            end else if (addr_q && byte_i == CMD_CPROG_GO) begin
              fire = 1'b1; code = OP_CPROG;
            end
          end
          SQ_CBPROG: begin
            if (byte_i == CMD_DATA_IN) begin
              state_d = SQ_CBPROG;
              addr_d  = addr_q;
            end else if (addr_q && byte_i == CMD_PROG_GO) begin
              fire = 1'b1; code = OP_CB_PROG;
            end
          end
          SQ_ERASE: begin
            if (addr_q && byte_i == CMD_ERASE_GO) begin
              fire = 1'b1; code = OP_ERASE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      addr_q  <= 1'b0;
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      valid_q <= fire;
      code_q  <= code;
    end
  end

  assign op_valid_o = valid_q;
  assign op_code_o  = code_q;
endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
  import nand_cmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            cle_i,
  input  logic            ale_i,
  input  logic [IO_W-1:0] io_i,
  input  logic            busy_i,
  input  logic            cache_busy_i,
  output logic            op_valid_o,
  output logic [OP_W-1:0] op_code_o
);
  logic            cmd_stb;
  logic            addr_stb;
  logic            cmd_ok;
  logic [IO_W-1:0] bus_byte;

  nand_bus_sampler u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .cle_i      (cle_i),
    .ale_i      (ale_i),
    .io_i       (io_i),
    .cmd_stb_o  (cmd_stb),
    .addr_stb_o (addr_stb),
    .byte_o     (bus_byte)
  );

  nand_busy_filter u_filter (
    .cmd_stb_i    (cmd_stb),
    .byte_i       (bus_byte),
    .busy_i       (busy_i),
    .cache_busy_i (cache_busy_i),
    .cmd_ok_o     (cmd_ok)
  );

  nand_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_ok_i   (cmd_ok),
    .addr_stb_i (addr_stb),
    .byte_i     (bus_byte),
    .op_valid_o (op_valid_o),
    .op_code_o  (op_code_o)
  );
endmodule

// File: rtl/nand_cmd_decoder_chk.sv
module nand_cmd_decoder_chk
  import nand_cmd_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic            cle_i,
  input logic [IO_W-1:0] io_i,
  input logic            busy_i,
  input logic            cache_busy_i,
  input logic            op_valid_o,
  input logic [OP_W-1:0] op_code_o
);
  logic we_d;
  logic cmd_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_d <= 1'b1;
    else         we_d <= we_i;
  end

  assign cmd_edge = we_i && !we_d && cle_i;

  // R1
  no_cmd_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_edge |=> !op_valid_o);

  // R8
  busy_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_edge && busy_i && io_i != 8'hFF && io_i != 8'h70 &&
     !(io_i == 8'h34 && cache_busy_i)) |=> !op_valid_o);

  // R10
  reset_cmd_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_edge && io_i == 8'hFF) |=> (op_valid_o && op_code_o == 4'd9));

  // R11
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o);

  // R11
  code_defined_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> (op_code_o <= 4'd11));
endmodule

bind nand_cmd_decoder nand_cmd_decoder_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .we_i         (we_i),
  .cle_i        (cle_i),
  .io_i         (io_i),
  .busy_i       (busy_i),
  .cache_busy_i (cache_busy_i),
  .op_valid_o   (op_valid_o),
  .op_code_o    (op_code_o)
);

// File: tb/nand_cmd_decoder_bench.sv
module nand_cmd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b1, cle = 1'b0, ale = 1'b0, busy = 1'b0, cbusy = 1'b0;
  logic [7:0] io = 8'h00;
  logic       op_valid;
  logic [3:0] op_code;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // model state: 0 idle, 1 read, 2 rdout, 3 prog, 4 cbprog, 5 erase
  int m_state = 0;
  bit m_addr  = 1'b0;

  always #2 clk = ~clk;

  nand_cmd_decoder u_nand_cmd_decoder (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .we_i         (we),
    .cle_i        (cle),
    .ale_i        (ale),
    .io_i         (io),
    .busy_i       (busy),
    .cache_busy_i (cbusy),
    .op_valid_o   (op_valid),
    .op_code_o    (op_code)
  );

  function automatic int confirm_code(int st, logic [7:0] d);
    if (st == 1 && d == 8'h30) return 0;
    if (st == 1 && d == 8'h35) return 6;
    if (st == 2 && d == 8'hE0) return 1;
    if (st == 3 && d == 8'h10) return 4;
    if (st == 3 && d == 8'h15) return 5;
    if (st == 4 && d == 8'h10) return 7;
    if (st == 5 && d == 8'hD0) return 8;
    return -1;
  endfunction

  function automatic int first_state(logic [7:0] d);
    case (d)
      8'h00: return 1;
      8'h05: return 2;
      8'h80: return 3;
      8'h85: return 4;
      8'h60: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int single_code(logic [7:0] d);
    case (d)
      8'h31: return 2;
      8'h34: return 3;
      8'h90: return 10;
      8'h70: return 11;
      default: return -1;
    endcase
  endfunction

  // returns expected code or -1 for no start
  task automatic model_step(input bit c, input bit a, input logic [7:0] d,
                            input bit b, input bit cb, output int exp_code);
    exp_code = -1;
    if (c) begin
      if (d == 8'hFF) begin
        m_state = 0; m_addr = 0; exp_code = 9;
      end else if (b && !(d == 8'h70 || (d == 8'h34 && cb))) begin
        exp_code = -1;
      end else if (m_state == 0) begin
        m_addr = 0;
        m_state = first_state(d);
        exp_code = single_code(d);
      end else if ((m_state == 3 || m_state == 4) && d == 8'h85) begin
        exp_code = -1;
      end else begin
        if (m_addr) exp_code = confirm_code(m_state, d);
        m_state = 0; m_addr = 0;
      end
    end else if (a) begin
      if (m_state != 0) m_addr = 1;
    end
  endtask

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one bus write; starts and ends on a falling clock edge
  task automatic bus_write(input bit c, input bit a, input logic [7:0] d,
                           input bit b, input bit cb, input string req);
    int exp_code;
    int act_code;
    we = 1'b0; cle = c; ale = a; io = d; busy = b; cbusy = cb;
    @(negedge clk);
    we = 1'b1;
    @(negedge clk);
    model_step(c, a, d, b, cb, exp_code);
    act_code = op_valid ? int'(op_code) : -1;
    check(req, act_code == exp_code, act_code, exp_code);
    @(negedge clk);
    check("R11 pulse width", !op_valid, int'(op_valid), 0);
  endtask

  task automatic cmd(input logic [7:0] d, input string req);
    bus_write(1'b1, 1'b0, d, 1'b0, 1'b0, req);
  endtask
  task automatic cmd_busy(input logic [7:0] d, input bit cb, input string req);
    bus_write(1'b1, 1'b0, d, 1'b1, cb, req);
  endtask
  task automatic addr(input string req);
    bus_write(1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, req);
  endtask
  task automatic data(input string req);
    bus_write(1'b0, 1'b0, 8'hC3, 1'b0, 1'b0, req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] pool [16];
    pool = '{8'h00, 8'h30, 8'h35, 8'h05, 8'hE0, 8'h80, 8'h85, 8'h10,
             8'h15, 8'h60, 8'hD0, 8'h31, 8'h34, 8'hFF, 8'h90, 8'h70};
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", !op_valid, int'(op_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R12 after reset", !op_valid, int'(op_valid), 0);
    // R12 no pending sequence: a lone confirm starts nothing
    cmd(8'h30, "R12");

    // R1: edges without cle
    bus_write(1'b0, 1'b0, 8'h70, 1'b0, 1'b0, "R1 data edge");
    bus_write(1'b0, 1'b1, 8'h70, 1'b0, 1'b0, "R1 addr edge");

    // R7
    cmd(8'h70, "R7 status");
    cmd(8'h90, "R7 signature");
    cmd(8'h31, "R7 cache read");
    cmd(8'h34, "R7 exit cache");

    // R2
    cmd(8'h00, "R2"); addr("R2"); addr("R2"); cmd(8'h30, "R2 read");
    cmd(8'h00, "R2"); addr("R2"); cmd(8'h35, "R2 copy read");

    // R3
    cmd(8'h05, "R3"); addr("R3"); cmd(8'hE0, "R3 rdout");

    // R4
    cmd(8'h80, "R4"); addr("R4"); data("R4"); cmd(8'h85, "R4 random in");
    addr("R4"); data("R4"); cmd(8'h10, "R4 page prog");
    cmd(8'h80, "R4"); addr("R4"); data("R4"); cmd(8'h15, "R4 cache prog");

    // R5
    cmd(8'h85, "R5"); addr("R5"); data("R5"); cmd(8'h10, "R5 copy prog");

    // R6
    cmd(8'h60, "R6"); addr("R6"); cmd(8'hD0, "R6 erase");

    // R9
    cmd(8'h60, "R9"); addr("R9"); cmd(8'h30, "R9 wrong confirm");
    cmd(8'hD0, "R9 after abort");
    cmd(8'h00, "R9"); cmd(8'h30, "R9 no address");
    cmd(8'h85, "R9"); addr("R9"); cmd(8'h15, "R9 copy with 15h");

    // R8
    cmd_busy(8'h70, 1'b0, "R8 status busy");
    cmd_busy(8'h90, 1'b0, "R8 signature busy");
    cmd_busy(8'h31, 1'b1, "R8 cache read busy");
    cmd_busy(8'h34, 1'b0, "R8 exit plain busy");
    cmd_busy(8'h34, 1'b1, "R8 exit cache busy");
    cmd(8'h60, "R8"); addr("R8");
    cmd_busy(8'hD0, 1'b0, "R8 confirm ignored");
    cmd_busy(8'h00, 1'b1, "R8 first ignored");
    cmd(8'hD0, "R8 pending kept");

    // R10
    cmd(8'h80, "R10"); addr("R10"); cmd(8'hFF, "R10 reset mid");
    cmd(8'h10, "R10 after reset");
    cmd_busy(8'hFF, 1'b0, "R10 reset busy");

    // random mix, scored against the model
    for (int i = 0; i < 800; i++) begin
      bit c, a, b, cb;
      logic [7:0] d;
      int sel;
      sel = int'($urandom % 10);
      c   = (sel < 6);
      a   = (sel >= 6 && sel < 9);
      b   = (($urandom % 5) == 0);
      cb  = $urandom % 2;
      d   = (($urandom % 8) == 0) ? 8'($urandom) : pool[$urandom % 16];
      bus_write(c, a, d, b, cb, "R8 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule